// File: doc/BRIEF.md
# Debug scan-chain register access unit

This block is a serial data-register chain for a test access port. A debug host reaches a small bank of 32-bit debug registers through it by shifting frames. Every frame holds a data word, a 5-bit register address and a direction bit. A write frame changes the addressed register when the update strobe arrives. A read frame only names a register. The value of that register comes back in the data field of the frame that follows.

The capture, shift and update strobes come from an external TAP controller as single-cycle enables on the block clock. The chain shifts one bit per shift strobe. The bit on `tdo` is always the lowest bit of the chain. Behind the chain sits a stub register bank that holds the following:
- a narrow control register;
- a read-only status word;
- a mailbox word that is cleared by a read;
- two match units with six registers each.

Because the mailbox loses its contents when read, the host has to end every read burst on a register that has no side effect. The status word is such a register, and it also counts the mailbox reads that have taken place.

Top module: `dbg_scan_access`

## Requirements
- R1: After synchronous reset every bank register, the mailbox and the mailbox read count are zero, and `tdo` is 0. The first frame after reset returns zero in its data field.
- R2: A frame is 38 bits and is shifted in least significant bit first. Bits 0..31 carry the data, bits 32..36 the address, and bit 37 the direction (1 = write, 0 = read). Captured bits 32..37 are always shifted out as zero, and `tdo` holds its value while neither capture nor shift is asserted.
- R3: A write takes effect only when the update strobe follows the frame. A write frame that is shifted in without an update leaves the addressed register unchanged.
- R4: The data field captured at the start of a frame carries the register named by the last updated frame if that frame was a read. If that frame was a write, the captured data field is zero.
- R5: The match units sit at addresses 0x08..0x0D and 0x10..0x15. Offsets 0..3 of each unit are full 32-bit read/write registers. Offsets 4 and 5 keep only bits 8:0, and their upper bits read as zero.
- R6: The control register at address 0x00 keeps bits 5:0, and its upper bits read as zero.
- R7: Every other address, apart from 0x04 and 0x05, is unmapped. A read of an unmapped address returns zero, and a write to one changes no register.
- R8: A write to address 0x05 loads the mailbox. A captured read of 0x05 returns the mailbox value, then clears the mailbox and increments an 8-bit read count. Address 0x04 is read-only and has no side effect: it returns version 0x6 in bits 31:28, the read count in bits 7:0 and zero in all other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tdi | input | 1 | Serial data into the chain |
| capture_en | input | 1 | Capture strobe: loads the pending read result into the chain |
| shift_en | input | 1 | Shift strobe: moves the chain one bit toward `tdo` |
| update_en | input | 1 | Update strobe: acts on the frame held in the chain |
| tdo | output | 1 | Serial data out, lowest chain bit |

## Verification
Directed frames first cover the reset value and then write and read back a known pattern at every class of address: full-width unit slots, narrow unit slots, the control register, unmapped space and the read-only status word. This separates a masking fault from an address decode fault. A mailbox write followed by two reads and a status read shows whether the clear-on-read and the count happen once per captured read and never on a status read. A write frame shifted without an update tells a write committed at update apart from one committed during shifting. A long run of frames with random direction, address and data then mixes read-after-write, read-after-read and repeated captures in orders the directed cases do not reach. Every frame is compared against a bench-side model of the bank.

// File: rtl/dbg_scan_pkg.sv
package dbg_scan_pkg;

    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 5;
    localparam int FRAME_W   = DATA_W + ADDR_W + 1;
    localparam int UNIT_REGS = 6;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic {
        DIR_READ  = 1'b0,
        DIR_WRITE = 1'b1
    } dir_e;

    // Packed layout matches the serial order: data lowest, direction highest.
    typedef struct packed {
        dir_e  dir;
        addr_t addr;
        word_t data;
    } frame_t;

    typedef struct packed {
        logic  en;
        addr_t addr;
        word_t data;
    } wr_req_t;

    typedef struct packed {
        logic  en;
        addr_t addr;
    } rd_req_t;

    localparam addr_t ADDR_CTRL    = 5'h00;
    localparam addr_t ADDR_STATUS  = 5'h04;
    localparam addr_t ADDR_MAILBOX = 5'h05;

    // Unit u occupies the eight-word slot starting at 8*(u+1), first six used.
    function automatic logic unit_hit(addr_t a, int u);
        return (a[4:3] == 2'(u + 1)) && (a[2:0] < 3'(UNIT_REGS));
    endfunction

    function automatic logic is_mapped(addr_t a, int n_units);
        logic hit;
        hit = (a == ADDR_CTRL) || (a == ADDR_STATUS) || (a == ADDR_MAILBOX);
        for (int u = 0; u < n_units; u++) begin
            hit = hit | unit_hit(a, u);
        end
        return hit;
    endfunction

endpackage

// File: rtl/dbg_match_unit.sv
module dbg_match_unit
    import dbg_scan_pkg::*;
#(
    parameter int NARROW_W = 9
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [2:0]  wr_off,
    input  word_t       wr_data,
    input  logic [2:0]  rd_off,
    output word_t       rd_word
);

    localparam int WIDE_SLOTS = 4;

    word_t words [UNIT_REGS];

    for (genvar k = 0; k < UNIT_REGS; k++) begin : g_slot
        localparam int W = (k >= WIDE_SLOTS) ? NARROW_W : DATA_W;
        logic [W-1:0] q;

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (wr_en && (wr_off == 3'(k))) begin
                q <= wr_data[W-1:0];
            end
        end

        assign words[k] = DATA_W'(q);
    end

    always_comb begin
        rd_word = '0;
        if (rd_off < 3'(UNIT_REGS)) begin
            rd_word = words[rd_off];
        end
    end

endmodule

// File: rtl/dbg_reg_bank.sv
module dbg_reg_bank
    import dbg_scan_pkg::*;
#(
    parameter int         NUM_UNITS = 2,
    parameter int         CTRL_W    = 6,
    parameter int         MCTRL_W   = 9,
    parameter int         CNT_W     = 8,
    parameter logic [3:0] VERSION   = 4'h6
) (
    input  logic             clk,
    input  logic             rst,
    input  wr_req_t          wr_req,
    input  rd_req_t          rd_req,
    output word_t            rd_data,
    output logic [CNT_W-1:0] side_cnt
);

    localparam int VER_W = 4;

    logic [CTRL_W-1:0] ctrl_q;
    word_t             mbox_q;
    logic [CNT_W-1:0]  cnt_q;
    word_t             unit_word [NUM_UNITS];
    word_t             unit_or;
    word_t             status_w;

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        dbg_match_unit #(
            .NARROW_W (MCTRL_W)
        ) u_unit (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_req.en && unit_hit(wr_req.addr, u)),
            .wr_off  (wr_req.addr[2:0]),
            .wr_data (wr_req.data),
            .rd_off  (rd_req.addr[2:0]),
            .rd_word (unit_word[u])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            mbox_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (rd_req.en && (rd_req.addr == ADDR_MAILBOX)) begin
                mbox_q <= '0;
                cnt_q  <= cnt_q + 1'b1;
            end
            if (wr_req.en) begin
                case (wr_req.addr)
                    ADDR_CTRL:    ctrl_q <= wr_req.data[CTRL_W-1:0];
                    ADDR_MAILBOX: mbox_q <= wr_req.data;
                    default:      ;
                endcase
            end
        end
    end

    always_comb begin
        unit_or = '0;
        for (int u = 0; u < NUM_UNITS; u++) begin
            if (unit_hit(rd_req.addr, u)) begin
                unit_or = unit_or | unit_word[u];
            end
        end
    end

    always_comb begin
        status_w = '0;
        status_w[DATA_W-1 -: VER_W] = VERSION;
        status_w[CNT_W-1:0]         = cnt_q;
    end

    always_comb begin
        case (rd_req.addr)
            ADDR_CTRL:    rd_data = DATA_W'(ctrl_q);
            ADDR_STATUS:  rd_data = status_w;
            ADDR_MAILBOX: rd_data = mbox_q;
            default:      rd_data = unit_or;
        endcase
    end

    assign side_cnt = cnt_q;

endmodule

// File: rtl/dbg_scan_chain.sv
module dbg_scan_chain
    import dbg_scan_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    tdi,
    input  logic    capture_en,
    input  logic    shift_en,
    input  logic    update_en,
    input  word_t   rd_data,
    output logic    tdo,
    output wr_req_t wr_req,
    output rd_req_t rd_req
);

    frame_t  sr;
    addr_t   sel_addr;
    logic    rd_pending;
    wr_req_t wr_q;

    // The bank is read only when the last updated frame asked for it.
    assign rd_req = '{en: capture_en && rd_pending, addr: sel_addr};

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '0;
        end else if (capture_en) begin
            sr <= '{dir: DIR_READ, addr: '0, data: (rd_pending ? rd_data : '0)};
        end else if (shift_en) begin
            sr <= frame_t'({tdi, sr[FRAME_W-1:1]});
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_addr   <= '0;
            rd_pending <= 1'b0;
            wr_q       <= '0;
        end else begin
            wr_q.en <= 1'b0;
            if (update_en) begin
                sel_addr   <= sr.addr;
                rd_pending <= (sr.dir == DIR_READ);
                if (sr.dir == DIR_WRITE) begin
                    wr_q <= '{en: 1'b1, addr: sr.addr, data: sr.data};
                end
            end
        end
    end

    assign wr_req = wr_q;
    assign tdo    = sr[0];

endmodule

// File: rtl/dbg_scan_access.sv
module dbg_scan_access
    import dbg_scan_pkg::*;
#(
    parameter int         NUM_UNITS = 2,
    parameter int         CTRL_W    = 6,
    parameter int         MCTRL_W   = 9,
    parameter int         CNT_W     = 8,
    parameter logic [3:0] VERSION   = 4'h6
) (
    input  logic clk,
    input  logic rst,
    input  logic tdi,
    input  logic capture_en,
    input  logic shift_en,
    input  logic update_en,
    output logic tdo
);

    wr_req_t          wr_req;
    rd_req_t          rd_req;
    word_t            rd_data;
    logic [CNT_W-1:0] side_cnt;

    dbg_scan_chain u_chain (
        .clk        (clk),
        .rst        (rst),
        .tdi        (tdi),
        .capture_en (capture_en),
        .shift_en   (shift_en),
        .update_en  (update_en),
        .rd_data    (rd_data),
        .tdo        (tdo),
        .wr_req     (wr_req),
        .rd_req     (rd_req)
    );

    dbg_reg_bank #(
        .NUM_UNITS (NUM_UNITS),
        .CTRL_W    (CTRL_W),
        .MCTRL_W   (MCTRL_W),
        .CNT_W     (CNT_W),
        .VERSION   (VERSION)
    ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_req   (wr_req),
        .rd_req   (rd_req),
        .rd_data  (rd_data),
        .side_cnt (side_cnt)
    );

endmodule

// File: rtl/dbg_scan_access_chk.sv
module dbg_scan_access_chk
    import dbg_scan_pkg::*;
#(
    parameter int NUM_UNITS = 2,
    parameter int CTRL_W    = 6,
    parameter int MCTRL_W   = 9,
    parameter int CNT_W     = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             capture_en,
    input logic             shift_en,
    input logic             update_en,
    input logic             tdo,
    input logic             wr_en,
    input logic             rd_en,
    input addr_t            rd_addr,
    input word_t            rd_data,
    input logic [CNT_W-1:0] side_cnt
);

    // R2: the serial output moves only on capture or shift
    p_tdo_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!shift_en && !capture_en) |=> $stable(tdo));

    // R3: a bank write is issued only right after an update strobe
    p_write_after_update_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(update_en));

    // R5: narrow match-unit slots never return upper bits
    p_narrow_upper_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (rd_addr[2:1] == 2'b10) && (rd_addr[4:3] != 2'b00))
        |-> (rd_data[DATA_W-1:MCTRL_W] == '0));

    // R6: control register upper bits read as zero
    p_ctrl_upper_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (rd_addr == ADDR_CTRL)) |-> (rd_data[DATA_W-1:CTRL_W] == '0));

    // R7: unmapped reads return zero
    p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !is_mapped(rd_addr, NUM_UNITS)) |-> (rd_data == '0));

    // R8: the read count moves only after a captured mailbox read
    p_count_on_mailbox_read_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(side_cnt) |-> ($past(rd_en) && ($past(rd_addr) == ADDR_MAILBOX)));

    // R8: reads happen only at capture
    p_read_only_at_capture_r8: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> capture_en);

endmodule

bind dbg_scan_access dbg_scan_access_chk #(
    .NUM_UNITS (NUM_UNITS),
    .CTRL_W    (CTRL_W),
    .MCTRL_W   (MCTRL_W),
    .CNT_W     (CNT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .capture_en (capture_en),
    .shift_en   (shift_en),
    .update_en  (update_en),
    .tdo        (tdo),
    .wr_en      (wr_req.en),
    .rd_en      (rd_req.en),
    .rd_addr    (rd_req.addr),
    .rd_data    (rd_data),
    .side_cnt   (side_cnt)
);

// File: tb/dbg_scan_access_tb_top.sv
module dbg_scan_access_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tdi = 1'b0;
    logic capture_en = 1'b0;
    logic shift_en = 1'b0;
    logic update_en = 1'b0;
    logic tdo;

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;

    // Bench-side model of the bank
    logic [31:0] m [32];
    logic [31:0] mb;
    logic [7:0]  cnt;
    bit          prev_rd;
    logic [4:0]  prev_addr;

    always #10 clk = ~clk;

    dbg_scan_access dut_i (
        .clk        (clk),
        .rst        (rst),
        .tdi        (tdi),
        .capture_en (capture_en),
        .shift_en   (shift_en),
        .update_en  (update_en),
        .tdo        (tdo)
    );

    function automatic bit in_unit(logic [4:0] a);
        return ((a >= 5'h08) && (a <= 5'h0D)) || ((a >= 5'h10) && (a <= 5'h15));
    endfunction

    function automatic string tag_of(logic [4:0] a);
        if (a == 5'h00) return "R6";
        if ((a == 5'h04) || (a == 5'h05)) return "R8";
        if (in_unit(a)) return "R5";
        return "R7";
    endfunction

    task automatic chk(input string tag, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model_read(input logic [4:0] a, output logic [31:0] v);
        v = 32'h0;
        if ((a == 5'h00) || in_unit(a)) begin
            v = m[a];
        end else if (a == 5'h04) begin
            v = {4'h6, 20'h0, cnt};
        end else if (a == 5'h05) begin
            v   = mb;
            mb  = 32'h0;
            cnt = cnt + 8'd1;
        end
    endtask

    task automatic model_write(input logic [4:0] a, input logic [31:0] d);
        if (a == 5'h00) begin
            m[a] = d & 32'h0000_003F;
        end else if (in_unit(a)) begin
            m[a] = (a[2:0] >= 3'd4) ? (d & 32'h0000_01FF) : d;
        end else if (a == 5'h05) begin
            mb = d;
        end
    endtask

    task automatic do_scan(input bit dir, input logic [4:0] addr, input logic [31:0] data,
                           input bit upd, output logic [37:0] got);
        logic [37:0] fr;
        fr = {dir, addr, data};
        @(negedge clk);
        capture_en = 1'b1;
        @(negedge clk);
        capture_en = 1'b0;
        shift_en   = 1'b1;
        for (int i = 0; i < 38; i++) begin
            tdi    = fr[i];
            got[i] = tdo;
            @(negedge clk);
        end
        shift_en = 1'b0;
        if (upd) begin
            update_en = 1'b1;
            @(negedge clk);
            update_en = 1'b0;
        end
    endtask

    task automatic scan_chk(input bit dir, input logic [4:0] addr, input logic [31:0] data,
                            input bit upd, input string tag);
        logic [31:0] exp;
        logic [37:0] got;
        string       t;
        exp = 32'h0;
        if (prev_rd) model_read(prev_addr, exp);
        if (tag != "") t = tag;
        else if (prev_rd) t = tag_of(prev_addr);
        else t = "R4";
        do_scan(dir, addr, data, upd, got);
        chk(t, got[31:0], exp, $sformatf("data field after addr %h", prev_addr));
        chk("R2", {26'h0, got[37:32]}, 32'h0, "captured upper field");
        if (upd) begin
            if (dir) model_write(addr, data);
            prev_rd   = !dir;
            prev_addr = addr;
        end
    endtask

    initial begin
        void'($urandom(32'd1357911));
        for (int i = 0; i < 32; i++) m[i] = 32'h0;
        mb = 32'h0; cnt = 8'h0; prev_rd = 1'b0; prev_addr = 5'h0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1", {31'h0, tdo}, 32'h0, "tdo after reset");
        scan_chk(1'b0, 5'h08, 32'h0, 1'b1, "R1");
        scan_chk(1'b0, 5'h05, 32'h0, 1'b1, "R1");
        scan_chk(1'b0, 5'h04, 32'h0, 1'b1, "R1");

        // Writes across every address class
        scan_chk(1'b1, 5'h08, 32'hA5A5_1234, 1'b1, "");
        scan_chk(1'b1, 5'h0C, 32'hFFFF_FFFF, 1'b1, "");
        scan_chk(1'b1, 5'h15, 32'h1234_5F0F, 1'b1, "");
        scan_chk(1'b1, 5'h13, 32'h0BAD_F00D, 1'b1, "");
        scan_chk(1'b1, 5'h00, 32'hFFFF_FFFF, 1'b1, "");
        scan_chk(1'b1, 5'h1F, 32'hDEAD_BEEF, 1'b1, "");
        scan_chk(1'b1, 5'h0E, 32'h7777_7777, 1'b1, "");
        scan_chk(1'b1, 5'h04, 32'h5555_5555, 1'b1, "");
        // Read back: R5 R6 R7 R8
        scan_chk(1'b0, 5'h08, 32'h0, 1'b1, "");
        scan_chk(1'b0, 5'h0C, 32'h0, 1'b1, "");
        scan_chk(1'b0, 5'h15, 32'h0, 1'b1, "");
        scan_chk(1'b0, 5'h13, 32'h0, 1'b1, "");
        scan_chk(1'b0, 5'h00, 32'h0, 1'b1, "");
        scan_chk(1'b0, 5'h1F, 32'h0, 1'b1, "");
        scan_chk(1'b0, 5'h0E, 32'h0, 1'b1, "");
        scan_chk(1'b0, 5'h04, 32'h0, 1'b1, "");
        scan_chk(1'b0, 5'h04, 32'h0, 1'b1, "");

        // R8: mailbox clear-on-read and read count
        scan_chk(1'b1, 5'h05, 32'hCAFE_F00D, 1'b1, "");
        scan_chk(1'b0, 5'h05, 32'h0, 1'b1, "");
        scan_chk(1'b0, 5'h05, 32'h0, 1'b1, "R8");
        scan_chk(1'b0, 5'h04, 32'h0, 1'b1, "R8");
        scan_chk(1'b0, 5'h04, 32'h0, 1'b1, "R8");

        // R3: write without update leaves the register alone
        scan_chk(1'b1, 5'h09, 32'h1111_2222, 1'b1, "");
        scan_chk(1'b1, 5'h09, 32'h9999_9999, 1'b0, "R4");
        scan_chk(1'b0, 5'h09, 32'h0, 1'b1, "R4");
        scan_chk(1'b0, 5'h04, 32'h0, 1'b1, "R3");

        // R4: read directly after a write returns zero in that frame
        scan_chk(1'b1, 5'h10, 32'h0F0F_0F0F, 1'b1, "");
        scan_chk(1'b0, 5'h10, 32'h0, 1'b1, "R4");
        scan_chk(1'b0, 5'h04, 32'h0, 1'b1, "R4");

        // Random frames
        for (int n = 0; n < 300; n++) begin
            logic [4:0]  a;
            logic [31:0] d;
            bit          w;
            a = 5'($urandom_range(0, 31));
            d = $urandom;
            w = bit'($urandom_range(0, 1));
            scan_chk(w, a, d, 1'b1, "");
        end
        scan_chk(1'b0, 5'h04, 32'h0, 1'b1, "");
        scan_chk(1'b0, 5'h04, 32'h0, 1'b1, "R8");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R1 watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule